// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a system-on-chip. A 16-bit up-counter is driven from one of three tick sources, and a power-of-four prescaler divides the chosen ticks. When the running counter reaches a programmed compare value, the block raises a single-cycle request to the reset controller. Software keeps the system alive by writing zero into the counter before the compare value is reached.

Four 16-bit registers sit behind a simple single-cycle register port. Writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high. Reads are combinational from the address. Only address bits [3:2] select a register. The tick sources are modelled as one-cycle enables in the system clock domain: bit 0 is the peripheral clock, bit 1 the real-time clock and bit 2 the external clock.

The block supports the usual reprogramming order with no stray reset request:
1. Disable the counter.
2. Write the divider code with no source selected.
3. Load the compare value.
4. Clear the counter.
5. Write the divider code again, now with a source.
6. Enable the counter.

Top module: `guard_timer`

## Requirements
- R1: After synchronous reset, all four registers read 0 and `rst_req` is low.
- R2: Register map by `bus_addr[3:2]`:
  - 0 is the compare value (16 bits).
  - 1 is the run flag (bit 0 only).
  - 2 is the counter.
  - 3 is control, using bits [5:0].
  - Every other bit reads as zero.
- R3: The counter moves only while the run flag is 1 and exactly one of control bits [2:0] is set. It moves only on a tick of the selected source (bit 0 peripheral, bit 1 real-time, bit 2 external), and by exactly one. With no source bit set, or more than one, it holds.
- R4: Control bits [5:3] hold a divider code k. The counter steps once per 4^k selected ticks for k = 0..5, and codes 6 and 7 divide by 1024.
- R5: Any write to the control register restarts the prescaler, so the next step needs a full divider period of ticks.
- R6: A write to the counter address loads the written value. Writing 0 is the keep-alive operation.
- R7: Writing 0 to the run flag freezes the counter, and writing 1 resumes it.
- R8: When the run flag is 1 and the counter equals the compare value, `rst_req` is high for exactly one cycle, on the cycle after equality begins. The counter then holds at the compare value, so no further pulse occurs until the counter is rewritten or the run flag is cycled.
- R9: The six-step reprogramming order listed above produces no `rst_req` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| src_tick | input | 3 | One-cycle tick enables: peripheral, real-time, external |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions watch four properties on every cycle:
- the counter never moves by anything other than one step on a prescaler tick;
- it stays frozen while stopped or parked at the compare value;
- no prescaler tick leaves without a single valid source;
- each reset request lasts one cycle and follows a real match.

Only the bench scenarios can show that the divide ratio for each code is exact, that a control write restarts the divider, and that register readback and masking are correct. The same holds for the absence of a pulse across the full reprogramming order. These are confirmed by exact counter values after counted bursts of ticks, alongside a behavioural model compared on every clock.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    localparam int REG_W    = 16;
    localparam int SRC_N    = 3;
    localparam int CODE_W   = 3;
    localparam int CODE_MAX = 5;
    localparam int DIV_W    = 2 * CODE_MAX;
    localparam int ADDR_W   = 4;

    typedef enum logic [1:0] {
        RG_CMP = 2'd0,
        RG_RUN = 2'd1,
        RG_CNT = 2'd2,
        RG_CTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [SRC_N-1:0]  src;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // terminal value of the divider for a code; codes above CODE_MAX saturate
    function automatic logic [DIV_W-1:0] div_last(input logic [CODE_W-1:0] code);
        int k;
        k = (int'(code) > CODE_MAX) ? CODE_MAX : int'(code);
        return DIV_W'((32'd1 << (2 * k)) - 32'd1);
    endfunction

    function automatic logic one_source(input logic [SRC_N-1:0] s);
        return $countones(s) == 1;
    endfunction

endpackage

// File: rtl/gtmr_regs.sv
module gtmr_regs
    import gtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  cnt_val,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [REG_W-1:0]  cmp_q,
    output logic              en_q,
    output ctl_t              ctl_q,
    output logic              ctl_wr,
    output logic              cnt_wr
);

    reg_sel_e sel;
    logic     wr_any;

    assign sel    = reg_sel_e'(bus_addr[3:2]);
    assign wr_any = bus_sel && bus_wr;
    assign ctl_wr = wr_any && (sel == RG_CTL);
    assign cnt_wr = wr_any && (sel == RG_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            en_q  <= 1'b0;
            ctl_q <= '0;
        end else begin
            if (wr_any && sel == RG_CMP) cmp_q <= bus_wdata;
            if (wr_any && sel == RG_RUN) en_q  <= bus_wdata[0];
            if (ctl_wr)                  ctl_q <= ctl_t'(bus_wdata[CTL_W-1:0]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            RG_CMP: bus_rdata = cmp_q;
            RG_RUN: bus_rdata[0] = en_q;
            RG_CNT: bus_rdata = cnt_val;
            RG_CTL: bus_rdata[CTL_W-1:0] = ctl_q;
        endcase
    end

endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale
    import gtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  ctl_t             ctl,
    input  logic [SRC_N-1:0] src_tick,
    output logic             tick_out
);

    logic [SRC_N-1:0] gated;
    logic [DIV_W-1:0] div_q;
    logic             adv;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        assign gated[i] = ctl.src[i] & src_tick[i];
    end

    assign adv      = en && one_source(ctl.src) && (|gated);
    assign tick_out = adv && (div_q == div_last(ctl.code));

    always_ff @(posedge clk) begin
        if (rst || clr)   div_q <= '0;
        else if (tick_out) div_q <= '0;
        else if (adv)      div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/gtmr_count.sv
module gtmr_count
    import gtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             step_tick,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic [REG_W-1:0] cmp,
    output logic [REG_W-1:0] cnt_q,
    output logic             pulse_q
);

    logic at_cmp;
    logic match;
    logic match_q;

    assign at_cmp = (cnt_q == cmp);
    assign match  = en && at_cmp;

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (step_tick && !at_cmp) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            match_q <= match;
            pulse_q <= match && !match_q;
        end
    end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import gtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [SRC_N-1:0]  src_tick,
    output logic              rst_req
);

    logic [REG_W-1:0] cmp_q;
    logic [REG_W-1:0] cnt_q;
    logic             en_q;
    ctl_t             ctl_q;
    logic             ctl_wr;
    logic             cnt_wr;
    logic             pre_tick;

    gtmr_regs u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt_q),
        .bus_rdata(bus_rdata), .cmp_q(cmp_q), .en_q(en_q), .ctl_q(ctl_q),
        .ctl_wr(ctl_wr), .cnt_wr(cnt_wr)
    );

    gtmr_prescale u_pre (
        .clk(clk), .rst(rst), .clr(ctl_wr), .en(en_q), .ctl(ctl_q),
        .src_tick(src_tick), .tick_out(pre_tick)
    );

    gtmr_count u_cnt (
        .clk(clk), .rst(rst), .en(en_q), .step_tick(pre_tick),
        .load(cnt_wr), .load_val(bus_wdata), .cmp(cmp_q),
        .cnt_q(cnt_q), .pulse_q(rst_req)
    );

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
    import gtmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en_q,
    input logic [REG_W-1:0] cnt_q,
    input logic [REG_W-1:0] cmp_q,
    input logic [SRC_N-1:0] ctl_src,
    input logic             cnt_wr,
    input logic             pre_tick,
    input logic             rst_req
);

    assert_one_cycle_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_pulse_on_match_R8: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(en_q && (cnt_q == cmp_q)));

    assert_hold_at_compare_R8: assert property (@(posedge clk) disable iff (rst)
        (en_q && (cnt_q == cmp_q) && !cnt_wr) |=> $stable(cnt_q));

    assert_frozen_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !cnt_wr) |=> $stable(cnt_q));

    assert_source_needed_R3: assert property (@(posedge clk) disable iff (rst)
        ($countones(ctl_src) != 1) |-> !pre_tick);

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
        (pre_tick && !cnt_wr && (cnt_q != cmp_q)) |=> (cnt_q == $past(cnt_q) + 16'd1));

    assert_no_drift_R6: assert property (@(posedge clk) disable iff (rst)
        (!pre_tick && !cnt_wr) |=> $stable(cnt_q));

endmodule

bind guard_timer guard_timer_chk u_chk (
    .clk(clk), .rst(rst), .en_q(en_q), .cnt_q(cnt_q), .cmp_q(cmp_q),
    .ctl_src(ctl_q.src), .cnt_wr(cnt_wr), .pre_tick(pre_tick), .rst_req(rst_req)
);

// File: tb/guard_timer_tb_top.sv
`timescale 1ns/1ps
module guard_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [2:0]  src_tick = 3'b000;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    guard_timer dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .rst_req(rst_req)
    );

    // behavioural reference model
    int m_cmp, m_en, m_cnt, m_ctl, m_div, m_prev, m_pulse;

    function automatic int ratio(input int code);
        return (code >= 5) ? 1024 : (1 << (2 * code));
    endfunction

    function automatic int model_read(input int a);
        case (a)
            0: return m_cmp;
            1: return m_en;
            2: return m_cnt;
            default: return m_ctl;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cmp = 0; m_en = 0; m_cnt = 0; m_ctl = 0; m_div = 0; m_prev = 0; m_pulse = 0;
        end else begin
            int srcs, nsrc, hit, adv, fire, wa, now_match;
            bit w;
            srcs = m_ctl & 7;
            nsrc = (srcs & 1) + ((srcs >> 1) & 1) + ((srcs >> 2) & 1);
            hit  = ((srcs & int'(src_tick)) != 0);
            adv  = (m_en == 1) && (nsrc == 1) && hit;
            fire = adv && (m_div == ratio(m_ctl >> 3) - 1);
            now_match = (m_en == 1) && (m_cnt == m_cmp);
            m_pulse = now_match && !m_prev;
            m_prev  = now_match;
            w  = bus_sel && bus_wr;
            wa = int'(bus_addr[3:2]);
            if (w && wa == 3) m_div = 0;
            else if (fire) m_div = 0;
            else if (adv) m_div = m_div + 1;
            if (w && wa == 2) m_cnt = int'(bus_wdata);
            else if (fire && m_cnt != m_cmp) m_cnt = (m_cnt + 1) % 65536;
            if (w && wa == 0) m_cmp = int'(bus_wdata);
            if (w && wa == 1) m_en = int'(bus_wdata[0]);
            if (w && wa == 3) m_ctl = int'(bus_wdata[5:0]);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 readback vs model", int'(bus_rdata), model_read(int'(bus_addr[3:2])));
            chk("R8 rst_req vs model", int'(rst_req), m_pulse);
            if (rst_req) pulses++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        v = int'(bus_rdata);
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic ticks(input logic [2:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; src_tick = m;
            @(posedge clk); #1; src_tick = 3'b000;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v, p0;
        idle(3);
        rst = 0;
        idle(1);
        // R1 reset state
        rd(4'h0, v); chk("R1 compare after reset", v, 0);
        rd(4'h4, v); chk("R1 run flag after reset", v, 0);
        rd(4'h8, v); chk("R1 counter after reset", v, 0);
        rd(4'hC, v); chk("R1 control after reset", v, 0);
        chk("R1 rst_req after reset", int'(rst_req), 0);

        // R2 map and masking
        wr(4'h0, 16'hA5C3); rd(4'h0, v); chk("R2 compare", v, 16'hA5C3);
        wr(4'h4, 16'hFFFF); rd(4'h4, v); chk("R2 run flag masked", v, 1);
        wr(4'h4, 16'h0000);
        wr(4'hC, 16'hFFFF); rd(4'hC, v); chk("R2 control masked", v, 16'h003F);
        wr(4'hC, 16'h0000);
        // R6 counter load
        wr(4'h8, 16'h1234); rd(4'h8, v); chk("R6 counter load", v, 16'h1234);
        wr(4'h8, 16'h0000); rd(4'h8, v); chk("R6 keep-alive zero", v, 0);

        // R3 source selection
        wr(4'h0, 16'hFFFF);
        wr(4'hC, 16'h0001);
        wr(4'h4, 16'h0001);
        ticks(3'b010, 5); rd(4'h8, v); chk("R3 unselected source ignored", v, 0);
        ticks(3'b001, 5); rd(4'h8, v); chk("R3 selected source steps", v, 5);
        wr(4'hC, 16'h0003);
        ticks(3'b011, 4); rd(4'h8, v); chk("R3 two sources hold", v, 5);
        wr(4'hC, 16'h0000);
        ticks(3'b111, 4); rd(4'h8, v); chk("R3 no source holds", v, 5);

        // R4 divide ratios
        wr(4'hC, 16'h0012); wr(4'h8, 16'h0000);
        ticks(3'b010, 47); rd(4'h8, v); chk("R4 div16 partial", v, 2);
        ticks(3'b010, 1);  rd(4'h8, v); chk("R4 div16 boundary", v, 3);
        wr(4'hC, 16'h000C); wr(4'h8, 16'h0000);
        ticks(3'b100, 9); rd(4'h8, v); chk("R4 div4", v, 2);
        wr(4'hC, 16'h003C); wr(4'h8, 16'h0000);
        ticks(3'b100, 1023); rd(4'h8, v); chk("R4 code7 before 1024", v, 0);
        ticks(3'b100, 1);    rd(4'h8, v); chk("R4 code7 at 1024", v, 1);

        // R5 control write restarts divider
        wr(4'hC, 16'h0009); wr(4'h8, 16'h0000);
        ticks(3'b001, 3);
        wr(4'hC, 16'h0009);
        ticks(3'b001, 3); rd(4'h8, v); chk("R5 divider restarted", v, 0);
        ticks(3'b001, 1); rd(4'h8, v); chk("R5 full period after restart", v, 1);

        // R7 stop and resume
        wr(4'h4, 16'h0000);
        ticks(3'b001, 8); rd(4'h8, v); chk("R7 frozen while stopped", v, 1);
        wr(4'h4, 16'h0001);
        ticks(3'b001, 4); rd(4'h8, v); chk("R7 resumes", v, 2);

        // R8 compare and single pulse
        wr(4'hC, 16'h0001); wr(4'h0, 16'h0003); wr(4'h8, 16'h0000);
        p0 = pulses;
        ticks(3'b001, 3); idle(3);
        chk("R8 one pulse at compare", pulses - p0, 1);
        ticks(3'b001, 5); idle(2);
        rd(4'h8, v); chk("R8 counter parks at compare", v, 3);
        chk("R8 no repeat pulse", pulses - p0, 1);
        wr(4'h8, 16'h0000);
        ticks(3'b001, 3); idle(3);
        chk("R8 pulse again after keep-alive", pulses - p0, 2);

        // R9 reprogramming order
        p0 = pulses;
        wr(4'h4, 16'h0000);
        wr(4'hC, 16'h0008);
        wr(4'h0, 16'h0005);
        wr(4'h8, 16'h0000);
        wr(4'hC, 16'h0009);
        wr(4'h4, 16'h0001);
        idle(4);
        chk("R9 no pulse during reprogram", pulses - p0, 0);
        ticks(3'b001, 4); rd(4'h8, v); chk("R9 counting after reprogram", v, 1);

        idle(2);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule